// File: doc/BRIEF.md
# Key-Protected Watchdog Register Interface

This block is the bus-facing register set of a watchdog timer. It holds three registers: an 8-bit tick counter, a control register and a reset control register. Two 16-bit write ports are used. At offset 0 the upper byte of the word is a key, and the key picks which register takes the lower byte. The same scheme applies at offset 2, where the reset control register is reached by word writes only. There the key decides whether the write clears the overflow flag or updates the reset-enable and reset-select bits. A write that carries the wrong key or the wrong size is dropped.

Reads are single bytes taken from their own offsets and come back one cycle later. The counter advances on an external tick while the run bit of the control register is set. When it wraps it sets the overflow flag. If resets are enabled, a one-cycle watchdog-overflow pulse is also raised.

Top module: `wdt_keyreg`

## Requirements
- R1: After synchronous reset the counter and the control register read 0x00, the reset control register reads 0x1F, and the overflow pulse is low.
- R2: A word write at offset 0 whose upper byte is 0x5A loads the lower byte into the counter. This load takes priority over a tick in the same cycle.
- R3: A word write at offset 0 whose upper byte is 0xA5 loads the lower byte into the control register.
- R4: A word write at offset 2 with the value 0xA500 clears the overflow flag (reset control bit 7). Reset-enable (bit 6) and reset-select (bit 5) keep their values.
- R5: A word write at offset 2 whose upper byte is 0x5A copies lower-byte bit 6 into reset-enable and bit 5 into reset-select. The overflow flag keeps its value.
- R6: Any other write leaves every register unchanged. This covers any other key, 0xA5 at offset 2 with a nonzero lower byte, any byte-sized write, and any write to offset 1 or 3.
- R7: The counter rises by one on each cycle in which tick is high and control bit 5 (run) is set. Otherwise it holds.
- R8: When the counter wraps from 0xFF to 0x00, the overflow flag is set at the same edge. The overflow pulse is high for exactly that one cycle, and only if reset-enable was 1 before the wrap.
- R9: If a wrap and a clearing write fall in the same cycle, the overflow flag ends up set.
- R10: A byte read returns its data on bus_rdata one cycle later. Offset 0 returns the control register, offset 1 the counter and offset 3 the reset control register, all with their values from before that cycle's edge. Word reads, reads at offset 2, and cycles with no read give 0x00.
- R11: Bits 4..0 of the reset control register always read as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable pulse from the prescaler |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | 1 | Access size: 1 = 16-bit word, 0 = byte |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 16 | Write word: key in [15:8], data in [7:0] |
| bus_rdata | output | 8 | Registered read byte |
| wdt_ovf_pulse | output | 1 | One-cycle watchdog-overflow indication |

## Verification
A write takes effect at the edge on which it is presented. A byte read issued in the next cycle therefore shows the new value on bus_rdata one edge after that, two edges after the write. A tick also moves the counter at its own edge. The overflow flag and the pulse change together at the wrap edge, so the pulse can be seen in the cycle after the final tick. The bench model takes the same inputs at each rising edge and computes that edge's results. The bench compares bus_rdata and the pulse at every falling edge, so every result is checked in the exact cycle it becomes due.

// File: rtl/wdt_keyreg_pkg.sv
package wdt_keyreg_pkg;

    localparam int DATA_W = 8;
    localparam int WORD_W = 2 * DATA_W;
    localparam int OFF_W  = 2;

    localparam logic [DATA_W-1:0] KEY_A = 8'h5A;
    localparam logic [DATA_W-1:0] KEY_B = 8'hA5;

    localparam logic [OFF_W-1:0] OFF_SHARED = 2'd0;
    localparam logic [OFF_W-1:0] OFF_COUNT  = 2'd1;
    localparam logic [OFF_W-1:0] OFF_RSTWR  = 2'd2;
    localparam logic [OFF_W-1:0] OFF_RSTRD  = 2'd3;

    localparam int RUN_BIT  = 5;
    localparam int FLAG_BIT = 7;
    localparam int REN_BIT  = 6;
    localparam int RSEL_BIT = 5;
    localparam int UNUSED_W = RSEL_BIT;

    typedef struct packed {
        logic              cnt_ld;
        logic              ctl_ld;
        logic              flag_clr;
        logic              rcfg_ld;
        logic [DATA_W-1:0] data;
    } wr_cmd_t;

    typedef struct packed {
        logic flag;
        logic ren;
        logic rsel;
    } rst_state_t;

    function automatic wr_cmd_t decode_write(
        input logic              wr,
        input logic              word,
        input logic [OFF_W-1:0]  off,
        input logic [WORD_W-1:0] wd
    );
        wr_cmd_t           c;
        logic [DATA_W-1:0] key;
        c      = '0;
        key    = wd[WORD_W-1:DATA_W];
        c.data = wd[DATA_W-1:0];
        if (wr && word) begin
            unique case (off)
                OFF_SHARED: begin
                    c.cnt_ld = (key == KEY_A);
                    c.ctl_ld = (key == KEY_B);
                end
                OFF_RSTWR: begin
                    c.flag_clr = (key == KEY_B) && (c.data == '0);
                    c.rcfg_ld  = (key == KEY_A);
                end
                default: ;
            endcase
        end
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_rst(input rst_state_t s);
        logic [DATA_W-1:0] v;
        v           = '0;
        v[FLAG_BIT] = s.flag;
        v[REN_BIT]  = s.ren;
        v[RSEL_BIT] = s.rsel;
        v[UNUSED_W-1:0] = '1;
        return v;
    endfunction

endpackage

// File: rtl/wdt_key_decode.sv
module wdt_key_decode
    import wdt_keyreg_pkg::*;
(
    input  logic              wr,
    input  logic              word,
    input  logic [OFF_W-1:0]  off,
    input  logic [WORD_W-1:0] wdata,
    output wr_cmd_t           cmd
);

    always_comb begin
        cmd = decode_write(wr, word, off, wdata);
    end

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    localparam logic [W-1:0] TOP = '1;

    assign wrap = step && !load && (cnt == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_rst_ctrl.sv
module wdt_rst_ctrl
    import wdt_keyreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wrap,
    input  logic       flag_clr,
    input  logic       rcfg_ld,
    input  logic       new_ren,
    input  logic       new_rsel,
    output rst_state_t st,
    output logic       pulse
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= wrap && st.ren;
            if (wrap) begin
                st.flag <= 1'b1;
            end else if (flag_clr) begin
                st.flag <= 1'b0;
            end
            if (rcfg_ld) begin
                st.ren  <= new_ren;
                st.rsel <= new_rsel;
            end
        end
    end

endmodule

// File: rtl/wdt_read_mux.sv
module wdt_read_mux
    import wdt_keyreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic              word,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] ctl,
    input  logic [DATA_W-1:0] cnt,
    input  logic [DATA_W-1:0] rstv,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] sel;

    always_comb begin
        sel = '0;
        if (rd && !word) begin
            unique case (off)
                OFF_SHARED: sel = ctl;
                OFF_COUNT:  sel = cnt;
                OFF_RSTRD:  sel = rstv;
                default:    sel = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= sel;
    end

endmodule

// File: rtl/wdt_keyreg.sv
module wdt_keyreg
    import wdt_keyreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_word,
    input  logic [OFF_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_ovf_pulse
);

    wr_cmd_t           cmd;
    logic [DATA_W-1:0] ctl_q;
    logic [DATA_W-1:0] cnt_q;
    logic              wrap;
    rst_state_t        rst_st;
    logic [DATA_W-1:0] rst_view;

    wdt_key_decode u_dec (
        .wr    (bus_wr),
        .word  (bus_word),
        .off   (bus_addr),
        .wdata (bus_wdata),
        .cmd   (cmd)
    );

    always_ff @(posedge clk) begin
        if (rst)             ctl_q <= '0;
        else if (cmd.ctl_ld) ctl_q <= cmd.data;
    end

    wdt_tick_counter #(.W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cmd.cnt_ld),
        .load_val (cmd.data),
        .step     (tick && ctl_q[RUN_BIT]),
        .cnt      (cnt_q),
        .wrap     (wrap)
    );

    wdt_rst_ctrl u_rctl (
        .clk      (clk),
        .rst      (rst),
        .wrap     (wrap),
        .flag_clr (cmd.flag_clr),
        .rcfg_ld  (cmd.rcfg_ld),
        .new_ren  (cmd.data[REN_BIT]),
        .new_rsel (cmd.data[RSEL_BIT]),
        .st       (rst_st),
        .pulse    (wdt_ovf_pulse)
    );

    assign rst_view = pack_rst(rst_st);

    wdt_read_mux u_rd (
        .clk   (clk),
        .rst   (rst),
        .rd    (bus_rd),
        .word  (bus_word),
        .off   (bus_addr),
        .ctl   (ctl_q),
        .cnt   (cnt_q),
        .rstv  (rst_view),
        .rdata (bus_rdata)
    );

endmodule

// File: rtl/wdt_keyreg_chk.sv
module wdt_keyreg_chk
    import wdt_keyreg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bus_word,
    input logic [OFF_W-1:0]  bus_addr,
    input logic [DATA_W-1:0] cnt,
    input logic              cnt_ld,
    input logic              wrap,
    input rst_state_t        st,
    input logic              pulse,
    input logic [DATA_W-1:0] rdata
);

    // R8: the overflow indication never lasts two cycles
    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    // R8: a pulse only follows a wrap while resets were enabled
    assert_pulse_needs_en_R8: assert property (@(posedge clk) disable iff (rst)
        pulse |-> ($past(st.ren) && st.flag));

    // R9: a wrap always leaves the flag set, even against a clear
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        wrap |=> st.flag);

    // R7: the counter only moves by a load or a single step
    assert_cnt_step_R7: assert property (@(posedge clk) disable iff (rst)
        (!cnt_ld) |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 8'd1));

    // R6: byte-sized writes never alter the reset configuration
    assert_byte_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_word) |=> ($stable(st.ren) && $stable(st.rsel) && !$fell(st.flag)));

    // R11: reset control reads always show the unused bits high
    assert_unused_ones_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_word && bus_addr == OFF_RSTRD) |=> (rdata[UNUSED_W-1:0] == '1));

endmodule

bind wdt_keyreg wdt_keyreg_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_word (bus_word),
    .bus_addr (bus_addr),
    .cnt      (cnt_q),
    .cnt_ld   (cmd.cnt_ld),
    .wrap     (wrap),
    .st       (rst_st),
    .pulse    (wdt_ovf_pulse),
    .rdata    (bus_rdata)
);

// File: tb/wdt_keyreg_tb.sv
module wdt_keyreg_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_word = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [7:0]  bus_rdata;
    logic        wdt_ovf_pulse;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_cnt = 0, m_ctl = 0, m_flag = 0, m_en = 0, m_sel = 0;
    int m_pulse = 0, m_rdata = 0;

    always #4 clk = ~clk;   // 125 MHz

    wdt_keyreg u_dut (
        .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdt_ovf_pulse(wdt_ovf_pulse)
    );

    function automatic int rst_byte();
        return (m_flag << 7) | (m_en << 6) | (m_sel << 5) | 32'h1F;
    endfunction

    always @(posedge clk) begin
        int key, lo, a, nr;
        bit okw, cl, tl, oc, ru, inc, wr_ap;
        cycles++;
        if (rst) begin
            m_cnt = 0; m_ctl = 0; m_flag = 0; m_en = 0; m_sel = 0;
            m_pulse = 0; m_rdata = 0;
        end else begin
            a = int'(bus_addr);
            key = int'(bus_wdata[15:8]);
            lo = int'(bus_wdata[7:0]);
            nr = 0;
            if (bus_rd && !bus_word) begin
                if (a == 0) nr = m_ctl;
                else if (a == 1) nr = m_cnt;
                else if (a == 3) nr = rst_byte();
            end
            okw = bus_wr && bus_word;
            cl = okw && a == 0 && key == 'h5A;
            tl = okw && a == 0 && key == 'hA5;
            oc = okw && a == 2 && key == 'hA5 && lo == 0;
            ru = okw && a == 2 && key == 'h5A;
            inc = tick && m_ctl[5];
            wr_ap = inc && !cl && m_cnt == 255;
            m_pulse = (wr_ap && m_en == 1) ? 1 : 0;
            if (wr_ap) m_flag = 1;
            else if (oc) m_flag = 0;
            if (ru) begin m_en = lo[6]; m_sel = lo[5]; end
            if (cl) m_cnt = lo;
            else if (inc) m_cnt = (m_cnt + 1) % 256;
            if (tl) m_ctl = lo;
            m_rdata = nr;
        end
    end

    always @(negedge clk) begin
        checks++;
        if (int'(bus_rdata) != m_rdata) begin
            fails++;
            $display("FAIL %s: bus_rdata actual=%02h expected=%02h", cur_req, bus_rdata, m_rdata[7:0]);
        end
        checks++;
        if (int'(wdt_ovf_pulse) != m_pulse) begin
            fails++;
            $display("FAIL %s: wdt_ovf_pulse actual=%0d expected=%0d", cur_req, wdt_ovf_pulse, m_pulse);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_wr = 0; bus_rd = 0; tick = 0; bus_word = 0;
        end
    endtask

    task automatic wr(logic [1:0] a, logic word, logic [15:0] d);
        @(negedge clk);
        bus_wr = 1; bus_rd = 0; bus_word = word; bus_addr = a; bus_wdata = d; tick = 0;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [1:0] a, logic word);
        @(negedge clk);
        bus_rd = 1; bus_wr = 0; bus_word = word; bus_addr = a; tick = 0;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_wr = 0; bus_rd = 0; tick = 1;
        end
        @(negedge clk);
        tick = 0;
    endtask

    task automatic read_all();
        rd(2'd0, 0); rd(2'd1, 0); rd(2'd3, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        cur_req = "R1";
        idle(3);
        @(negedge clk); rst = 0;
        read_all();                                 // R1: 00, 00, 1F

        cur_req = "R2"; wr(2'd0, 1, 16'h5A12); rd(2'd1, 0);
        cur_req = "R3"; wr(2'd0, 1, 16'hA5C4); rd(2'd0, 0);

        cur_req = "R6";
        wr(2'd0, 1, 16'h1234); wr(2'd0, 0, 16'h5A77); wr(2'd0, 0, 16'hA577);
        wr(2'd2, 1, 16'hA501); wr(2'd2, 0, 16'h5A60); wr(2'd1, 1, 16'h5A33);
        wr(2'd3, 1, 16'h5A60); wr(2'd2, 1, 16'h5B60);
        read_all();

        cur_req = "R5"; wr(2'd2, 1, 16'h5A60); rd(2'd3, 0);   // expect 7F
        cur_req = "R11"; wr(2'd2, 1, 16'h5A20); rd(2'd3, 0);  // expect 3F

        cur_req = "R7";
        wr(2'd0, 1, 16'hA500); ticks(3); rd(2'd1, 0);         // run off: hold
        wr(2'd0, 1, 16'hA520); ticks(5); rd(2'd1, 0);         // 17
        cur_req = "R2";
        @(negedge clk); bus_wr = 1; bus_word = 1; bus_addr = 0; bus_wdata = 16'h5AF0; tick = 1;
        @(negedge clk); bus_wr = 0; tick = 0;
        rd(2'd1, 0);                                           // F0, load wins

        cur_req = "R8";
        wr(2'd2, 1, 16'h5A40);
        wr(2'd0, 1, 16'h5AFD); ticks(3); idle(2); rd(2'd3, 0); rd(2'd1, 0);
        cur_req = "R4"; wr(2'd2, 1, 16'hA500); rd(2'd3, 0);   // 5F

        cur_req = "R9";
        wr(2'd0, 1, 16'h5AFF);
        @(negedge clk); bus_wr = 1; bus_word = 1; bus_addr = 2; bus_wdata = 16'hA500; tick = 1;
        @(negedge clk); bus_wr = 0; tick = 0;
        idle(1); rd(2'd3, 0);

        cur_req = "R8";
        wr(2'd2, 1, 16'hA500); wr(2'd2, 1, 16'h5A00);
        wr(2'd0, 1, 16'h5AFE); ticks(2); idle(2); rd(2'd3, 0); // no pulse, flag set

        cur_req = "R10";
        rd(2'd1, 1); rd(2'd2, 0); rd(2'd0, 1); idle(2);
        @(negedge clk); bus_wr = 1; bus_rd = 1; bus_word = 1; bus_addr = 0; bus_wdata = 16'h5A44;
        @(negedge clk); bus_word = 0; bus_addr = 1; bus_rd = 1; bus_wr = 0;
        @(negedge clk); bus_rd = 0;

        cur_req = "R6";
        for (int i = 0; i < 400; i++) begin
            int k;
            @(negedge clk);
            k = $urandom_range(0, 3);
            bus_wr = $urandom_range(0, 2) == 0;
            bus_rd = $urandom_range(0, 1) == 0;
            bus_word = $urandom_range(0, 3) != 0;
            bus_addr = 2'($urandom_range(0, 3));
            bus_wdata[15:8] = (k == 0) ? 8'h5A : (k == 1) ? 8'hA5 : 8'($urandom);
            bus_wdata[7:0] = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
            tick = $urandom_range(0, 1) == 1;
        end
        idle(3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule